// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block serves one warp-wide scratchpad access against a set of single-ported banks of 32-bit words. A request carries one word address per thread, an active mask, a read/write flag and per-thread write data. The block splits the warp into a lower and an upper half of threads and serves the lower half first. In every cycle, each bank serves one distinct address. Threads that share that exact address are served together, so reads of one word are broadcast. Threads whose addresses differ but fall in the same bank wait for later cycles.

The bank storage sits inside the block. Read results are kept per thread and are valid when the one-cycle done flag rises. A new request is taken only while the block is idle. The cost of a half in cycles is the largest number of distinct active addresses that land in any one bank, with a minimum of one cycle. This lets a caller predict the latency of any stride or permutation.

Top module: `scratch_arbiter`

## Requirements
- R1: The bank of a word address is its low four bits (address modulo 16), and the remaining upper bits select the row inside that bank. Consecutive words therefore fall in consecutive banks. Within one cycle, all threads served by one bank carry the same address.
- R2: Threads 0..15 form the first half and threads 16..31 form the second half. The second half starts only after every active thread of the first half is served. The total serving time is the sum of the two halves' costs.
- R3: When all active threads of a half fall in different banks, that half takes exactly one cycle.
- R4: When the threads of a half all read one identical address, they all receive that word in one cycle.
- R5: The cost of a half equals the largest count of distinct active addresses in any single bank. A stride of 2 costs 2 cycles per half and a stride of 8 costs 8, while odd strides cost 1. Every serving cycle completes at least one pending thread.
- R6: When several active threads of a write request target the same address, the data of the highest-numbered of those threads is what remains stored.
- R7: Per-thread read data is valid when done is high. Done is high for exactly one cycle, which is the cycle after the second half's last serving cycle. The block is idle in the next cycle.
- R8: A request presented while the block is busy is ignored, and it leaves the storage unchanged.
- R9: Inactive threads take no bank slot and their read data keeps its previous value. A half with no active thread costs one cycle. Write requests leave all read data unchanged.
- R10: After reset, done and busy are low, all read data is zero and all storage words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken only when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mask | input | 32 | Active thread mask, bit t for thread t |
| req_addr | input | 256 | Word address of thread t at bits [8t+7:8t] |
| req_wdata | input | 1024 | Write data of thread t at bits [32t+31:32t] |
| busy | output | 1 | Request in progress (serving or done cycle) |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 1024 | Read data of thread t at bits [32t+31:32t] |

## Verification
The assertions check on every cycle that each bank serves a single address and that only pending threads are served. They also check that a serving cycle always makes progress, that no pending bit is set again while a request is in flight, and that done is a lone pulse followed by idle. Only the bench's scenarios can show the exact cycle cost of the stride, permutation, broadcast and masked patterns, and the data that is returned. The scenarios also show that the highest thread wins on a shared write and that a request arriving while busy leaves the storage untouched.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SERVE = 2'd1,
    ST_DONE  = 2'd2
  } arb_state_t;
endpackage

// File: rtl/sp_bank_pick.sv
// Chooses, for one bank, the lowest pending thread of the current half that
// maps to this bank, and marks every pending thread sharing its address.
module sp_bank_pick #(
  parameter int HALF    = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int BANK_W  = 4,
  parameter int BANK_ID = 0
) (
  input  logic [HALF-1:0]        pend,
  input  logic [HALF*ADDR_W-1:0] addr,
  input  logic [HALF*DATA_W-1:0] wdata,
  output logic                   gnt_valid,
  output logic [ADDR_W-1:0]      gnt_addr,
  output logic [DATA_W-1:0]      gnt_wdata,
  output logic [HALF-1:0]        served
);
  localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return a[BANK_W-1:0];
  endfunction

  always_comb begin
    gnt_valid = 1'b0;
    gnt_addr  = '0;
    for (int j = 0; j < HALF; j++) begin
      if (!gnt_valid && pend[j] && bank_of(addr[j*ADDR_W +: ADDR_W]) == MY_BANK) begin
        gnt_valid = 1'b1;
        gnt_addr  = addr[j*ADDR_W +: ADDR_W];
      end
    end
  end

  always_comb begin
    gnt_wdata = '0;
    for (int j = 0; j < HALF; j++) begin
      served[j] = gnt_valid && pend[j] && (addr[j*ADDR_W +: ADDR_W] == gnt_addr);
      if (served[j]) gnt_wdata = wdata[j*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/sp_bank.sv
// One single-ported bank: combinational read, clocked write.
module sp_bank #(
  parameter int ROWS   = 16,
  parameter int DATA_W = 32,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [ROWS];

  assign rdata = mem[row];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (we) begin
      mem[row] <= wdata;
    end
  end
endmodule

// File: rtl/scratch_arbiter.sv
module scratch_arbiter
  import sp_pkg::*;
#(
  parameter int THREADS = 32,
  parameter int BANKS   = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [THREADS-1:0]        req_mask,
  input  logic [THREADS*ADDR_W-1:0] req_addr,
  input  logic [THREADS*DATA_W-1:0] req_wdata,
  output logic                      busy,
  output logic                      done,
  output logic [THREADS*DATA_W-1:0] rd_data
);
  localparam int HALF   = THREADS / 2;
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROWS   = (1 << ADDR_W) / BANKS;
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1;

  arb_state_t                state;
  logic                      half_sel;
  logic                      wr_q;
  logic [THREADS-1:0]        pend;
  logic [THREADS*ADDR_W-1:0] addr_q;
  logic [THREADS*DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0]         rd_q [THREADS];

  // Named internal events, observed by the checker.
  logic                      serving;
  logic                      half_done;
  logic [HALF-1:0]           pend_half;
  logic [HALF-1:0]           served;
  logic [HALF*ADDR_W-1:0]    half_addr;
  logic [HALF*DATA_W-1:0]    half_wdata;

  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return a[BANK_W-1:0];
  endfunction

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return ROW_W'(a >> BANK_W);
  endfunction

  assign serving    = (state == ST_SERVE);
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);
  assign pend_half  = half_sel ? pend[THREADS-1 -: HALF] : pend[HALF-1:0];
  assign half_addr  = half_sel ? addr_q[THREADS*ADDR_W-1 -: HALF*ADDR_W]
                               : addr_q[HALF*ADDR_W-1:0];
  assign half_wdata = half_sel ? wdata_q[THREADS*DATA_W-1 -: HALF*DATA_W]
                               : wdata_q[HALF*DATA_W-1:0];
  assign half_done  = serving && ((pend_half & ~served) == '0);

  logic              gnt_valid [BANKS];
  logic [ADDR_W-1:0] gnt_addr  [BANKS];
  logic [DATA_W-1:0] gnt_wdata [BANKS];
  logic [HALF-1:0]   gnt_served[BANKS];
  logic [DATA_W-1:0] bank_rdata[BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    sp_bank_pick #(
      .HALF(HALF), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .BANK_ID(b)
    ) u_pick (
      .pend      (pend_half),
      .addr      (half_addr),
      .wdata     (half_wdata),
      .gnt_valid (gnt_valid[b]),
      .gnt_addr  (gnt_addr[b]),
      .gnt_wdata (gnt_wdata[b]),
      .served    (gnt_served[b])
    );

    sp_bank #(.ROWS(ROWS), .DATA_W(DATA_W)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (serving && wr_q && gnt_valid[b]),
      .row   (row_of(gnt_addr[b])),
      .wdata (gnt_wdata[b]),
      .rdata (bank_rdata[b])
    );
  end

  always_comb begin
    served = '0;
    for (int b = 0; b < BANKS; b++) served = served | gnt_served[b];
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_out
    assign rd_data[t*DATA_W +: DATA_W] = rd_q[t];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      half_sel <= 1'b0;
      wr_q     <= 1'b0;
      pend     <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          state    <= ST_SERVE;
          half_sel <= 1'b0;
          wr_q     <= req_write;
          pend     <= req_mask;
          addr_q   <= req_addr;
          wdata_q  <= req_wdata;
        end
        ST_SERVE: begin
          if (half_sel) pend[THREADS-1 -: HALF] <= pend_half & ~served;
          else          pend[HALF-1:0]          <= pend_half & ~served;
          if (half_done) begin
            if (half_sel) state <= ST_DONE;
            else          half_sel <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < THREADS; t++) rd_q[t] <= '0;
    end else if (serving && !wr_q) begin
      for (int j = 0; j < HALF; j++) begin
        if (served[j])
          rd_q[half_sel ? HALF + j : j] <= bank_rdata[bank_of(half_addr[j*ADDR_W +: ADDR_W])];
      end
    end
  end
endmodule

// File: rtl/sp_arb_chk.sv
module sp_arb_chk #(
  parameter int THREADS = 32,
  parameter int HALF    = 16,
  parameter int ADDR_W  = 8,
  parameter int BANK_W  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic                   done,
  input logic                   serving,
  input logic [THREADS-1:0]     pend,
  input logic [HALF-1:0]        pend_half,
  input logic [HALF-1:0]        served,
  input logic [HALF*ADDR_W-1:0] half_addr
);
  logic clash;
  always_comb begin
    clash = 1'b0;
    for (int j = 0; j < HALF; j++) begin
      for (int k = j + 1; k < HALF; k++) begin
        if (served[j] && served[k] &&
            half_addr[j*ADDR_W +: BANK_W] == half_addr[k*ADDR_W +: BANK_W] &&
            half_addr[j*ADDR_W +: ADDR_W] != half_addr[k*ADDR_W +: ADDR_W])
          clash = 1'b1;
      end
    end
  end

  // R1
  bank_one_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serving |-> !clash);

  // R9
  served_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serving |-> ((served & ~pend_half) == '0));

  // R5
  progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (serving && pend_half != '0) |-> (served != '0));

  // R8
  no_new_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ((pend & ~$past(pend)) == '0)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

bind scratch_arbiter sp_arb_chk #(
  .THREADS(THREADS), .HALF(HALF), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .serving(serving),
  .pend(pend), .pend_half(pend_half), .served(served), .half_addr(half_addr)
);

// File: tb/sim_scratch_arbiter.sv
module sim_scratch_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int TH = 32, HF = 16, AW = 8, DW = 32, NB = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [TH-1:0]    req_mask = '0;
  logic [TH*AW-1:0] req_addr = '0;
  logic [TH*DW-1:0] req_wdata = '0;
  logic busy, done;
  logic [TH*DW-1:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  scratch_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data)
  );

  typedef struct {
    string            tag;
    int               cycles;
    logic [TH*DW-1:0] rd;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0, pending_jobs = 0;
  logic [DW-1:0]    model [256];
  logic [TH*DW-1:0] exp_rd = '0;
  logic [AW-1:0]    s_addr [TH];
  logic [DW-1:0]    s_wd   [TH];

  task automatic check(input string tag, input bit ok, input logic [TH*DW-1:0] act,
                       input logic [TH*DW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic int half_cost(input int h, input logic [TH-1:0] m);
    int worst = 1;
    for (int b = 0; b < NB; b++) begin
      int cnt = 0;
      for (int j = h*HF; j < h*HF + HF; j++) begin
        if (m[j] && (s_addr[j] % NB) == b) begin
          bit seen = 0;
          for (int k = h*HF; k < j; k++)
            if (m[k] && s_addr[k] == s_addr[j]) seen = 1;
          if (!seen) cnt++;
        end
      end
      if (cnt > worst) worst = cnt;
    end
    return worst;
  endfunction

  // Driver: predicts and queues the result, then presents the request.
  task automatic issue(input string tag, input logic wr, input logic [TH-1:0] m);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    e.tag = tag;
    e.cycles = half_cost(0, m) + half_cost(1, m);
    for (int t = 0; t < TH; t++) begin
      if (m[t]) begin
        if (wr) model[s_addr[t]] = s_wd[t];
        else    exp_rd[t*DW +: DW] = model[s_addr[t]];
      end
    end
    e.rd = exp_rd;
    exp_q.push_back(e);
    pending_jobs++;
    for (int t = 0; t < TH; t++) begin
      req_addr[t*AW +: AW]  = s_addr[t];
      req_wdata[t*DW +: DW] = s_wd[t];
    end
    req_mask  = m;
    req_write = wr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_all();
    while (pending_jobs != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: counts serving cycles and compares on each done pulse.
  initial begin
    int cnt = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && busy && !done) cnt++;
      if (rst_n && done) begin
        if (exp_q.size() == 0) begin
          check("R7 unexpected done", 1'b0, '0, '0);
        end else begin
          e = exp_q.pop_front();
          check({e.tag, " cycles"}, cnt == e.cycles, TH*DW'(cnt), TH*DW'(e.cycles));
          check({e.tag, " data"}, rd_data === e.rd, rd_data, e.rd);
        end
        cnt = 0;
        @(negedge clk);
        check("R7 done one cycle, then idle", !done && !busy, {done, busy}, '0);
        pending_jobs--;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check("watchdog", 1'b0, '0, '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 reset done/busy", !done && !busy, {done, busy}, '0);
    check("R10 reset rd_data", rd_data == '0, rd_data, '0);

    // R1 R3: stride-1 write then read, one cycle per half
    for (int t = 0; t < TH; t++) begin s_addr[t] = AW'(t); s_wd[t] = 32'h1000 + t; end
    issue("R1 stride1 write", 1'b1, '1);
    // R5: stride-8 write fills more rows (8 cycles per half)
    for (int t = 0; t < TH; t++) begin s_addr[t] = AW'(t*8 + 1); s_wd[t] = 32'hB000 + t; end
    issue("R5 stride8 write", 1'b1, '1);
    for (int t = 0; t < TH; t++) s_addr[t] = AW'(t);
    issue("R1 R3 stride1 read", 1'b0, '1);
    // R3: permutation inside each half, all banks distinct
    for (int t = 0; t < TH; t++) s_addr[t] = AW'(((t*5 + 3) % 16) + 16*(t/16));
    issue("R3 permutation read", 1'b0, '1);
    // R4: broadcast of one word
    for (int t = 0; t < TH; t++) s_addr[t] = AW'(7);
    issue("R4 broadcast read", 1'b0, '1);
    // R5: stride 2 -> 2 per half
    for (int t = 0; t < TH; t++) s_addr[t] = AW'(t*2);
    issue("R5 stride2 read", 1'b0, '1);
    // R5: odd stride 3 -> 1 per half
    for (int t = 0; t < TH; t++) s_addr[t] = AW'(t*3);
    issue("R5 stride3 read", 1'b0, '1);
    // R2 R5: stride 8 read -> 8 per half, 16 total
    for (int t = 0; t < TH; t++) s_addr[t] = AW'(t*8 + 1);
    issue("R2 R5 stride8 read", 1'b0, '1);
    // R8: a write presented while busy must be ignored
    for (int t = 0; t < TH; t++) begin
      req_addr[t*AW +: AW] = AW'(5); req_wdata[t*DW +: DW] = 32'hDEAD_0000 + t;
    end
    req_write = 1'b1; req_mask = '1; req_valid = 1'b1;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    wait_all();
    for (int t = 0; t < TH; t++) s_addr[t] = AW'(5);
    issue("R8 busy request ignored", 1'b0, '1);

    // R6: all threads write address 9, highest thread wins
    for (int t = 0; t < TH; t++) begin s_addr[t] = AW'(9); s_wd[t] = 32'hA0 + t; end
    issue("R6 shared write", 1'b1, '1);
    issue("R6 shared write readback", 1'b0, '1);
    // R6: only lower half writes address 10, thread 15 wins
    for (int t = 0; t < TH; t++) begin s_addr[t] = AW'(10); s_wd[t] = 32'hC0 + t; end
    issue("R6 half write", 1'b1, 32'h0000_FFFF);
    issue("R6 half write readback", 1'b0, 32'h0000_0001);

    // R9: sparse mask, bank 0 conflicts in first half, empty second half
    for (int t = 0; t < TH; t++) s_addr[t] = AW'(t*16);
    issue("R9 sparse mask read", 1'b0, 32'h0000_00F0);
    // R9 R2: only upper half active
    for (int t = 0; t < TH; t++) s_addr[t] = AW'(t*2 + 1);
    issue("R9 R2 upper half only", 1'b0, 32'hFFFF_0000);
    wait_all();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule